// File: doc/BRIEF.md
# Reconfigurable Hybrid Conversion Result Assembler

This block builds the final output word of a two-stage converter whose coarse stage is a successive-approximation search and whose fine stage is a 16-step ramp. During the fine phase it watches the comparator. On the first clock at which the comparator level differs from its level one clock earlier, it latches the running ramp code. The direction of the change does not matter. It also holds the ten coarse decisions, which are latched on the first clock of the fine phase.

When the frame's output strobe arrives, the block packs both parts into a 14-bit registered word, and the packing depends on a 2-bit resolution mode. The eight most significant coarse decisions always fill the top of the word. The six low bits carry the remaining coarse bits and the 4-bit fine code. Unused low bits are set to zero. The word then holds its value until the next strobe.

Top module: `hybrid_result_assembler`

## Requirements
- R1: While reset is asserted, and after it is released until the first output strobe, `result` is 0.
- R2: During the fine phase (`fine_en` high), the fine code stores `ramp_code` on the first clock at which `cmp_out` differs from its value one clock earlier. A rising change and a falling change are treated the same, and a change on the very first fine clock counts.
- R3: After the first change in a fine phase, further comparator changes in that phase do not alter the stored fine code.
- R4: If the comparator does not change during a fine phase, the fine code is 4'b1111.
- R5: In every mode except 2'b01, `result[13:6]` equals bits 9..2 of the coarse code. The coarse code is the value of `sar_code` on the first clock of the fine phase, which is the clock at which `fine_en` rises.
- R6: Mode 2'b11 (14-bit): `result[5:4]` = coarse bits 1..0 and `result[3:0]` = the fine code.
- R7: Mode 2'b10 (13-bit): `result[5]` = coarse bit 1, `result[4:1]` = the fine code, and `result[0]` = 0.
- R8: Mode 2'b00 (12-bit): `result[5:2]` = the fine code and `result[1:0]` = 0.
- R9: Mode 2'b01 has no resolution assigned. A strobe in this mode makes `result` read 0.
- R10: `result` changes only on the clock edge at which `out_strobe` is high, using the `mode` value sampled on that edge. At all other edges it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_out | input | 1 | Comparator decision |
| fine_en | input | 1 | High during the ramp (fine) phase |
| ramp_code | input | 4 | Running ramp step code |
| sar_code | input | 10 | Coarse decisions, with the MSB first |
| mode | input | 2 | Resolution select: 00 = 12-bit, 10 = 13-bit, 11 = 14-bit, 01 = off |
| out_strobe | input | 1 | Output clock of the frame |
| result | output | 14 | Registered result word |

## Verification
The frames use both starting comparator levels, so that rising and falling crossings are both exercised. Crossings are placed on the first step, on a middle step and on the last step, and some frames have no crossing at all. This separates correct edge detection from detection of one level only, and it tests the default code of all ones. Frames with a second crossing show whether a later crossing overwrites the first. The same coarse and fine values are packed under all four modes, so that a swapped or wrongly shifted low field shows up. A frame that runs without a strobe, and a reset applied partway through, check that the word holds its value and clears as required.

// File: rtl/hra_pkg.sv
package hra_pkg;
    typedef enum logic [1:0] {
        RES_12  = 2'b00,
        RES_OFF = 2'b01,
        RES_13  = 2'b10,
        RES_14  = 2'b11
    } res_mode_e;

    // number of zero-filled LSBs for a mode
    function automatic int unsigned pad_bits(input res_mode_e m);
        case (m)
            RES_14:  return 0;
            RES_13:  return 1;
            default: return 2;
        endcase
    endfunction
endpackage

// File: rtl/hra_fine_capture.sv
module hra_fine_capture #(
    parameter int RAMP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fine_en,
    input  logic              cmp_out,
    input  logic [RAMP_W-1:0] ramp_code,
    output logic              phase_start,
    output logic              phase_prev,
    output logic              got,
    output logic [RAMP_W-1:0] fine_code
);
    typedef struct packed {
        logic              cmp;
        logic              phase;
        logic              got;
        logic [RAMP_W-1:0] code;
    } cap_t;

    cap_t st_d, st_q;

    assign phase_start = fine_en && !st_q.phase;

    always_comb begin
        st_d       = st_q;
        st_d.cmp   = cmp_out;
        st_d.phase = fine_en;
        if (phase_start) begin
            st_d.got  = 1'b0;
            st_d.code = '1;
        end
        if (fine_en && (cmp_out != st_q.cmp) && !st_d.got) begin
            st_d.got  = 1'b1;
            st_d.code = ramp_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cmp: 1'b0, phase: 1'b0, got: 1'b0, code: '1};
        else        st_q <= st_d;
    end

    assign phase_prev = st_q.phase;
    assign got        = st_q.got;
    assign fine_code  = st_q.code;
endmodule

// File: rtl/hra_coarse_hold.sv
module hra_coarse_hold #(
    parameter int SAR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SAR_W-1:0] sar_code,
    output logic [SAR_W-1:0] coarse
);
    logic [SAR_W-1:0] coarse_d, coarse_q;

    always_comb coarse_d = load ? sar_code : coarse_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) coarse_q <= '0;
        else        coarse_q <= coarse_d;
    end

    assign coarse = coarse_q;
endmodule

// File: rtl/hra_low_packer.sv
module hra_low_packer
    import hra_pkg::*;
#(
    parameter int RAMP_W = 4,
    parameter int SPARE  = 2
) (
    input  res_mode_e               mode,
    input  logic [SPARE-1:0]        coarse_low,
    input  logic [RAMP_W-1:0]       fine_code,
    output logic [RAMP_W+SPARE-1:0] low
);
    localparam int LOW_W = RAMP_W + SPARE;

    logic [LOW_W-1:0] keep_mask;
    logic [LOW_W-1:0] coarse_part;
    logic [LOW_W-1:0] fine_part;
    int unsigned      pad;

    always_comb begin
        pad         = pad_bits(mode);
        keep_mask   = ~((LOW_W'(1) << (RAMP_W + pad)) - LOW_W'(1));
        coarse_part = (LOW_W'(coarse_low) << RAMP_W) & keep_mask;
        fine_part   = LOW_W'(fine_code) << pad;
        low         = coarse_part | fine_part;
    end
endmodule

// File: rtl/hybrid_result_assembler.sv
module hybrid_result_assembler
    import hra_pkg::*;
#(
    parameter int SAR_W  = 10,
    parameter int RAMP_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmp_out,
    input  logic                    fine_en,
    input  logic [RAMP_W-1:0]       ramp_code,
    input  logic [SAR_W-1:0]        sar_code,
    input  logic [1:0]              mode,
    input  logic                    out_strobe,
    output logic [SAR_W+RAMP_W-1:0] result
);
    localparam int OUT_W = SAR_W + RAMP_W;
    localparam int SPARE = 2;
    localparam int LOW_W = RAMP_W + SPARE;

    logic              phase_start, phase_prev, got;
    logic [RAMP_W-1:0] fine_code;
    logic [SAR_W-1:0]  coarse;
    logic [LOW_W-1:0]  low;
    res_mode_e         mode_e;

    assign mode_e = res_mode_e'(mode);

    hra_fine_capture #(.RAMP_W(RAMP_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .fine_en(fine_en), .cmp_out(cmp_out),
        .ramp_code(ramp_code), .phase_start(phase_start), .phase_prev(phase_prev),
        .got(got), .fine_code(fine_code)
    );

    hra_coarse_hold #(.SAR_W(SAR_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(phase_start), .sar_code(sar_code),
        .coarse(coarse)
    );

    hra_low_packer #(.RAMP_W(RAMP_W), .SPARE(SPARE)) u_pack (
        .mode(mode_e), .coarse_low(coarse[SPARE-1:0]), .fine_code(fine_code),
        .low(low)
    );

    typedef struct packed {
        logic [OUT_W-1:0] word;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (out_strobe) begin
            if (mode_e == RES_OFF) out_d.word = '0;
            else                   out_d.word = {coarse[SAR_W-1:SPARE], low};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result = out_q.word;
endmodule

// File: rtl/hra_checker.sv
module hra_checker #(
    parameter int SAR_W  = 10,
    parameter int RAMP_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    fine_en,
    input logic                    out_strobe,
    input logic [1:0]              mode,
    input logic                    phase_prev,
    input logic                    got,
    input logic [RAMP_W-1:0]       fine_code,
    input logic [SAR_W-1:0]        coarse,
    input logic [SAR_W+RAMP_W-1:0] result
);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_strobe |=> $stable(result));

    assert_off_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_strobe && mode == 2'b01) |=> (result == '0));

    assert_pad12_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_strobe && mode == 2'b00) |=> (result[1:0] == 2'b00));

    assert_pad13_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_strobe && mode == 2'b10) |=> (result[0] == 1'b0));

    assert_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_strobe && mode != 2'b01) |=>
            (result[SAR_W+RAMP_W-1:RAMP_W+2] == $past(coarse[SAR_W-1:2])));

    assert_first_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (got && fine_en && phase_prev) |=> $stable(fine_code));
endmodule

bind hybrid_result_assembler hra_checker #(.SAR_W(SAR_W), .RAMP_W(RAMP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fine_en(fine_en), .out_strobe(out_strobe),
    .mode(mode), .phase_prev(phase_prev), .got(got), .fine_code(fine_code),
    .coarse(coarse), .result(result)
);

// File: tb/hybrid_result_assembler_bench.sv
module hybrid_result_assembler_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_out = 1'b0;
    logic        fine_en = 1'b0;
    logic [3:0]  ramp_code = '0;
    logic [9:0]  sar_code = '0;
    logic [1:0]  mode = 2'b11;
    logic        out_strobe = 1'b0;
    logic [13:0] result;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    hybrid_result_assembler u_hybrid_result_assembler (
        .clk(clk), .rst_n(rst_n), .cmp_out(cmp_out), .fine_en(fine_en),
        .ramp_code(ramp_code), .sar_code(sar_code), .mode(mode),
        .out_strobe(out_strobe), .result(result)
    );

    // Vectors: mode, coarse code, starting comparator level,
    // first and second change step (16 = none), expected word.
    localparam int NV = 10;
    localparam logic [1:0]  V_MODE [NV] = '{2'b11, 2'b10, 2'b00, 2'b01, 2'b11,
                                            2'b11, 2'b11, 2'b10, 2'b00, 2'b10};
    localparam logic [9:0]  V_SAR  [NV] = '{10'h2A5, 10'h3FF, 10'h155, 10'h3FF, 10'h000,
                                            10'h003, 10'h200, 10'h001, 10'h003, 10'h000};
    localparam logic        V_CMP0 [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0,
                                            1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
    localparam logic [4:0]  V_T1   [NV] = '{5'd9, 5'd3, 5'd12, 5'd5, 5'd16,
                                            5'd0, 5'd4, 5'd15, 5'd16, 5'd16};
    localparam logic [4:0]  V_T2   [NV] = '{5'd16, 5'd16, 5'd16, 5'd16, 5'd16,
                                            5'd16, 5'd7, 5'd16, 5'd16, 5'd16};
    localparam logic [13:0] V_EXP  [NV] = '{14'h2A59, 14'h3FE6, 14'h1570, 14'h0000, 14'h000F,
                                            14'h0030, 14'h2004, 14'h001E, 14'h003C, 14'h001E};

    task automatic check(input string req, input logic [13:0] got_v, input logic [13:0] exp_v);
        checks++;
        if (got_v !== exp_v) begin
            failures++;
            $display("FAIL %s: result=%h expected=%h", req, got_v, exp_v);
        end
    endtask

    // drives one frame; inputs change on falling edges
    task automatic run_frame(input logic [1:0] m, input logic [9:0] s, input logic c0,
                             input logic [4:0] t1, input logic [4:0] t2, input bit strobe);
        @(negedge clk);
        mode = m; sar_code = s; cmp_out = c0; fine_en = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 16; k++) begin
            fine_en   = 1'b1;
            ramp_code = 4'(k);
            cmp_out   = c0 ^ (5'(k) >= t1) ^ (5'(k) >= t2);
            @(negedge clk);
        end
        fine_en = 1'b0;
        sar_code = ~s;
        @(negedge clk);
        out_strobe = strobe;
        @(negedge clk);
        out_strobe = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset value", result, 14'h0000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 after release", result, 14'h0000);

        // R2 R3 R4 R5 R6 R7 R8 R9 exercised through the vector walk
        for (int i = 0; i < NV; i++) begin
            run_frame(V_MODE[i], V_SAR[i], V_CMP0[i], V_T1[i], V_T2[i], 1'b1);
            case (V_MODE[i])
                2'b11:   check($sformatf("R6 R5 R2 vec %0d", i), result, V_EXP[i]);
                2'b10:   check($sformatf("R7 R5 R2 vec %0d", i), result, V_EXP[i]);
                2'b00:   check($sformatf("R8 R5 R4 vec %0d", i), result, V_EXP[i]);
                default: check($sformatf("R9 vec %0d", i), result, V_EXP[i]);
            endcase
        end

        // R3: many later toggles do not move the first capture
        run_frame(2'b11, 10'h000, 1'b0, 5'd2, 5'd3, 1'b1);
        check("R3 later toggles ignored", result, 14'h0002);

        // R10: a full frame without strobe leaves the word unchanged
        run_frame(2'b11, 10'h3FF, 1'b1, 5'd6, 5'd16, 1'b0);
        check("R10 hold without strobe", result, 14'h0002);
        repeat (5) @(negedge clk);
        check("R10 hold idle", result, 14'h0002);

        // R10: mode changes between strobes do not touch the word
        mode = 2'b01;
        repeat (2) @(negedge clk);
        check("R10 mode change no strobe", result, 14'h0002);

        // R9: a strobe in mode 01 after a valid word clears it
        run_frame(2'b11, 10'h3FF, 1'b0, 5'd1, 5'd16, 1'b1);
        check("R6 before off", result, 14'h3FF1);
        run_frame(2'b01, 10'h3FF, 1'b0, 5'd1, 5'd16, 1'b1);
        check("R9 off clears", result, 14'h0000);

        // R1: reset in the middle of operation
        run_frame(2'b11, 10'h123, 1'b0, 5'd8, 5'd16, 1'b1);
        check("R6 before reset", result, 14'h1238);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset", result, 14'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        finished = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!finished && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: finished=0 expected=1");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule